// File: doc/BRIEF.md
# Auto-Incrementing Register Access Controller

This block sits behind the byte layer of an I2C-style target and turns a stream of byte strobes into register accesses. The first byte written in a transaction becomes the register pointer. Every later byte, read or written, goes to the register the pointer names. After that byte the pointer either moves on by one or stays where it is, depending on the kind of register addressed.

Most addresses are ordinary one-byte registers in the main map, which lives outside this block. The controller reaches that map through a simple combinational address/strobe port. Four addresses are multi-byte registers, so repeated bytes stay on the same address.

Two addresses form an indirect window into a local bank of 200 general-purpose bytes. One address holds the bank index. The other passes bank data through at that index, and the index moves forward by one for every byte transferred through the window. The pointer stays put on both window addresses.

Top module: `regacc_ctrl`

## Requirements
- R1: After reset the register pointer is 0x00 (seen on `map_addr`), the bank index is 0 and `rdata` is 0x00.
- R2: A byte with `byte_vld`=1, `txn_start`=1 and `byte_rd`=0 loads `wdata` into the pointer. It does not strobe `map_we` or `map_re`.
- R3: A data byte to any address that is not in the hold set and not a window address advances the pointer by one. A two-byte read after loading 0x00 therefore reads main-map addresses 0x00 and then 0x01.
- R4: The pointer is 8 bits wide and steps from 0xFF to 0x00.
- R5: Data bytes at addresses 0x29, 0x2D, 0x4F and 0x7F leave the pointer unchanged.
- R6: A data write at index address 0x60 sets the bank index to `wdata`, and a data read there returns the current index. The pointer stays at 0x60.
- R7: An index write of 200 or more sets the index to 199.
- R8: A data byte at window address 0x61 reads or writes bank entry [index] and then adds one to the index. The pointer stays at 0x61.
- R9: An index advance from 199 goes to 0.
- R10: The data for a read byte appears on `rdata` after the clock edge that accepts the strobe. It holds until the next read byte.
- R11: A data byte to a main-map address drives `map_addr` = pointer in the strobe cycle. A write also drives `map_we`=1 with `map_wdata`=`wdata`, and a read drives `map_re`=1. Bytes at 0x60 or 0x61 never raise `map_we` or `map_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One byte is transferred this cycle |
| byte_rd | input | 1 | 1 = the byte is a read, 0 = a write |
| txn_start | input | 1 | The byte is the first of its transaction |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Last read data byte |
| map_addr | output | 8 | Current register pointer, the main-map address |
| map_we | output | 1 | Main-map write strobe |
| map_re | output | 1 | Main-map read strobe |
| map_wdata | output | 8 | Main-map write data |
| map_rdata | input | 8 | Main-map read data (combinational from `map_addr`) |

## Verification
The main-map strobes, address and write data are combinational from the strobe cycle. The bench latches them 1 ns after it drives the byte, which is before the accepting edge. Pointer and index updates show one edge later. `rdata` is also valid one edge later, so each transfer task returns at the falling edge that follows the accepting edge and checks those results there. The bench reads the pointer from `map_addr` while idle and reads the index back as a 0x60 data read. It models the main map as `map_rdata = map_addr ^ 0xA5`, which gives every address a distinct expected value.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ACC_MAP_STEP  = 2'd0,
        ACC_MAP_HOLD  = 2'd1,
        ACC_BANK_IDX  = 2'd2,
        ACC_BANK_DATA = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic  load;
        logic  step;
        byte_t load_val;
    } ptr_cmd_t;

    typedef struct packed {
        logic  idx_we;
        logic  data_acc;
        logic  data_we;
        byte_t wval;
    } bank_cmd_t;

    localparam int unsigned HOLD_CNT = 4;
    localparam byte_t HOLD_LIST [HOLD_CNT] = '{8'h29, 8'h2D, 8'h4F, 8'h7F};

    function automatic logic is_hold(input byte_t a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < HOLD_CNT; i++) begin
            if (a == HOLD_LIST[i]) hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic acc_kind_e classify(input byte_t a, input byte_t idx_reg,
                                           input byte_t data_reg);
        if (a == idx_reg)       return ACC_BANK_IDX;
        else if (a == data_reg) return ACC_BANK_DATA;
        else if (is_hold(a))    return ACC_MAP_HOLD;
        else                    return ACC_MAP_STEP;
    endfunction

endpackage

// File: rtl/regacc_ptr.sv
module regacc_ptr
    import regacc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ptr_cmd_t cmd,
    output byte_t    ptr
);

    always_ff @(posedge clk) begin
        if (rst)           ptr <= '0;
        else if (cmd.load) ptr <= cmd.load_val;
        else if (cmd.step) ptr <= ptr + byte_t'(1);
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd.step && !cmd.load) |=> (ptr == byte_t'($past(ptr) + byte_t'(1)))) // R3
        else $error("pointer did not step");

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (ptr == $past(cmd.load_val))) // R2
        else $error("pointer did not load");

    AST_PTR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cmd.step && !cmd.load) |=> $stable(ptr)) // R5
        else $error("pointer moved without command");

endmodule

// File: rtl/regacc_bank.sv
module regacc_bank
    import regacc_pkg::*;
#(
    parameter int unsigned DEPTH = 200
) (
    input  logic      clk,
    input  logic      rst,
    input  bank_cmd_t cmd,
    output byte_t     idx_out,
    output byte_t     rd_data
);

    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned LAST = DEPTH - 1;

    logic [IW-1:0] idx;
    logic [IW-1:0] idx_nxt;
    logic [IW-1:0] idx_clamped;
    byte_t         mem [DEPTH];

    always_comb begin
        idx_clamped = (32'(cmd.wval) >= DEPTH) ? IW'(LAST) : IW'(cmd.wval);
        idx_nxt     = (32'(idx) == LAST) ? '0 : idx + IW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)               idx <= '0;
        else if (cmd.idx_we)   idx <= idx_clamped;
        else if (cmd.data_acc) idx <= idx_nxt;
    end

    always_ff @(posedge clk) begin
        if (cmd.data_acc && cmd.data_we) mem[idx] <= cmd.wval;
    end

    assign rd_data = mem[idx];
    assign idx_out = byte_t'(idx);

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(idx) < DEPTH) // R7
        else $error("bank index out of range");

    AST_IDX_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (cmd.idx_we && 32'(cmd.wval) >= DEPTH) |=> (32'(idx) == LAST)) // R7
        else $error("index not clamped");

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cmd.data_acc && !cmd.idx_we && 32'(idx) == LAST) |=> (idx == '0)) // R9
        else $error("index did not wrap");

endmodule

// File: rtl/regacc_ctrl.sv
module regacc_ctrl
    import regacc_pkg::*;
#(
    parameter int unsigned BANK_DEPTH = 200,
    parameter logic [7:0]  IDX_REG    = 8'h60,
    parameter logic [7:0]  DATA_REG   = 8'h61
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld,
    input  logic       byte_rd,
    input  logic       txn_start,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] map_addr,
    output logic       map_we,
    output logic       map_re,
    output logic [7:0] map_wdata,
    input  logic [7:0] map_rdata
);

    byte_t     ptr;
    byte_t     bank_idx;
    byte_t     bank_rd;
    byte_t     rd_sel;
    acc_kind_e kind;
    logic      addr_byte;
    logic      data_byte;
    logic      is_map;
    ptr_cmd_t  pcmd;
    bank_cmd_t bcmd;

    always_comb begin
        addr_byte = byte_vld && txn_start && !byte_rd;
        data_byte = byte_vld && !addr_byte;
        kind      = classify(ptr, IDX_REG, DATA_REG);
        is_map    = (kind == ACC_MAP_STEP) || (kind == ACC_MAP_HOLD);

        pcmd.load     = addr_byte;
        pcmd.load_val = wdata;
        pcmd.step     = data_byte && (kind == ACC_MAP_STEP);

        bcmd.idx_we   = data_byte && !byte_rd && (kind == ACC_BANK_IDX);
        bcmd.data_acc = data_byte && (kind == ACC_BANK_DATA);
        bcmd.data_we  = !byte_rd;
        bcmd.wval     = wdata;

        unique case (kind)
            ACC_BANK_IDX:  rd_sel = bank_idx;
            ACC_BANK_DATA: rd_sel = bank_rd;
            default:       rd_sel = map_rdata;
        endcase
    end

    regacc_ptr u_ptr (
        .clk (clk),
        .rst (rst),
        .cmd (pcmd),
        .ptr (ptr)
    );

    regacc_bank #(.DEPTH(BANK_DEPTH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .cmd     (bcmd),
        .idx_out (bank_idx),
        .rd_data (bank_rd)
    );

    always_ff @(posedge clk) begin
        if (rst)                       rdata <= '0;
        else if (data_byte && byte_rd) rdata <= rd_sel;
    end

    assign map_addr  = ptr;
    assign map_we    = data_byte && !byte_rd && is_map;
    assign map_re    = data_byte && byte_rd && is_map;
    assign map_wdata = wdata;

    always_comb begin
        if (!rst) begin
            AST_WINDOW_NO_MAP: assert (!((map_we || map_re) &&
                                ((map_addr == IDX_REG) || (map_addr == DATA_REG)))) // R11
                else $error("window address reached main map");
            AST_ONE_STROBE: assert ($onehot0({map_we, map_re})) // R11
                else $error("both map strobes high");
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(byte_vld && byte_rd) |=> $stable(rdata)) // R10
        else $error("rdata changed without read");

endmodule

// File: tb/regacc_ctrl_test.sv
module regacc_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic       byte_rd = 1'b0;
    logic       txn_start = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] map_addr;
    logic       map_we;
    logic       map_re;
    logic [7:0] map_wdata;
    logic [7:0] map_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] l_addr;
    logic       l_we, l_re;
    logic [7:0] l_wdata;

    always #4 clk = ~clk;

    assign map_rdata = map_addr ^ 8'hA5;

    regacc_ctrl uut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_rd(byte_rd),
        .txn_start(txn_start), .wdata(wdata), .rdata(rdata),
        .map_addr(map_addr), .map_we(map_we), .map_re(map_re),
        .map_wdata(map_wdata), .map_rdata(map_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic rd, input logic st, input logic [7:0] d);
        @(negedge clk);
        byte_vld = 1'b1; byte_rd = rd; txn_start = st; wdata = d;
        #1;
        l_addr = map_addr; l_we = map_we; l_re = map_re; l_wdata = map_wdata;
        @(negedge clk);
        byte_vld = 1'b0; txn_start = 1'b0; byte_rd = 1'b0;
    endtask

    task automatic set_idx(input logic [7:0] v);
        xfer(1'b0, 1'b1, 8'h60);
        xfer(1'b0, 1'b0, v);
    endtask

    task automatic read_idx(output logic [7:0] v);
        xfer(1'b0, 1'b1, 8'h60);
        xfer(1'b1, 1'b0, 8'h00);
        v = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1", "pointer after reset", map_addr, 8'h00);
        chk("R1", "rdata after reset", rdata, 8'h00);
        read_idx(v);
        chk("R1", "index after reset", v, 8'h00);
    endtask

    task automatic t_load;
        xfer(1'b0, 1'b1, 8'h10);
        chk("R2", "no write strobe on address byte", {7'd0, l_we}, 8'h00);
        chk("R2", "no read strobe on address byte", {7'd0, l_re}, 8'h00);
        chk("R2", "pointer loaded", map_addr, 8'h10);
    endtask

    task automatic t_step_read;
        xfer(1'b0, 1'b1, 8'h00);
        xfer(1'b1, 1'b0, 8'h00);
        chk("R3", "first read address", l_addr, 8'h00);
        chk("R11", "read strobe", {7'd0, l_re}, 8'h01);
        chk("R10", "first read data", rdata, 8'h00 ^ 8'hA5);
        xfer(1'b1, 1'b0, 8'h00);
        chk("R3", "second read address", l_addr, 8'h01);
        chk("R10", "second read data", rdata, 8'h01 ^ 8'hA5);
        chk("R3", "pointer after two reads", map_addr, 8'h02);
    endtask

    task automatic t_write_step;
        logic [7:0] keep;
        keep = rdata;
        xfer(1'b0, 1'b1, 8'h20);
        xfer(1'b0, 1'b0, 8'h5A);
        chk("R11", "write strobe", {7'd0, l_we}, 8'h01);
        chk("R11", "write address", l_addr, 8'h20);
        chk("R11", "write data", l_wdata, 8'h5A);
        chk("R3", "pointer after write", map_addr, 8'h21);
        chk("R10", "rdata held over writes", rdata, keep);
    endtask

    task automatic t_wrap;
        xfer(1'b0, 1'b1, 8'hFF);
        xfer(1'b1, 1'b0, 8'h00);
        chk("R4", "read at 0xFF", rdata, 8'hFF ^ 8'hA5);
        chk("R4", "pointer wrapped", map_addr, 8'h00);
    endtask

    task automatic t_hold;
        logic [7:0] regs [4] = '{8'h29, 8'h2D, 8'h4F, 8'h7F};
        for (int i = 0; i < 4; i++) begin
            xfer(1'b0, 1'b1, regs[i]);
            xfer(1'b1, 1'b0, 8'h00);
            xfer(1'b0, 1'b0, 8'h33);
            chk("R5", "hold register write address", l_addr, regs[i]);
            xfer(1'b1, 1'b0, 8'h00);
            chk("R5", "hold register pointer", map_addr, regs[i]);
            chk("R5", "hold register data", rdata, regs[i] ^ 8'hA5);
        end
    endtask

    task automatic t_idx;
        logic [7:0] v;
        set_idx(8'h05);
        chk("R11", "no map write at index reg", {7'd0, l_we}, 8'h00);
        chk("R6", "pointer holds at index reg", map_addr, 8'h60);
        xfer(1'b1, 1'b0, 8'h00);
        chk("R6", "index read back", rdata, 8'h05);
        chk("R6", "pointer still at index reg", map_addr, 8'h60);
        set_idx(8'hC8);
        read_idx(v);
        chk("R7", "clamp 200", v, 8'd199);
        set_idx(8'hFF);
        read_idx(v);
        chk("R7", "clamp 255", v, 8'd199);
        set_idx(8'hC7);
        read_idx(v);
        chk("R7", "199 kept", v, 8'd199);
    endtask

    task automatic t_bank;
        logic [7:0] v;
        logic [7:0] pat [3] = '{8'hAA, 8'hBB, 8'hCC};
        set_idx(8'd10);
        xfer(1'b0, 1'b1, 8'h61);
        for (int i = 0; i < 3; i++) begin
            xfer(1'b0, 1'b0, pat[i]);
            chk("R11", "no map write at window", {7'd0, l_we}, 8'h00);
        end
        chk("R8", "pointer holds at window", map_addr, 8'h61);
        read_idx(v);
        chk("R8", "index after 3 writes", v, 8'd13);
        set_idx(8'd10);
        xfer(1'b0, 1'b1, 8'h61);
        for (int i = 0; i < 3; i++) begin
            xfer(1'b1, 1'b0, 8'h00);
            chk("R8", "window read data", rdata, pat[i]);
            chk("R11", "no map read at window", {7'd0, l_re}, 8'h00);
        end
        read_idx(v);
        chk("R8", "index after 3 reads", v, 8'd13);
    endtask

    task automatic t_bank_wrap;
        logic [7:0] v;
        logic [7:0] pat [3] = '{8'h11, 8'h22, 8'h33};
        set_idx(8'd198);
        xfer(1'b0, 1'b1, 8'h61);
        for (int i = 0; i < 3; i++) xfer(1'b0, 1'b0, pat[i]);
        read_idx(v);
        chk("R9", "index wrapped", v, 8'd1);
        set_idx(8'd198);
        xfer(1'b0, 1'b1, 8'h61);
        for (int i = 0; i < 3; i++) begin
            xfer(1'b1, 1'b0, 8'h00);
            chk("R9", "data across wrap", rdata, pat[i]);
        end
        set_idx(8'd0);
        xfer(1'b0, 1'b1, 8'h61);
        xfer(1'b1, 1'b0, 8'h00);
        chk("R9", "entry 0 after wrap", rdata, 8'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load();
        t_step_read();
        t_write_step();
        t_wrap();
        t_hold();
        t_idx();
        t_bank();
        t_bank_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule